// File: doc/BRIEF.md
# Sleep Entry and Wake Sequencer

This block decides when a small processor core goes to sleep, which clock domains are gated while it sleeps, and how it comes back. Software arms sleep with an enable bit and picks a mode with a three-bit selector. A one-cycle pulse from the core reports that a sleep instruction has executed. If the enable bit is set on that cycle, the core is halted and the chosen mode's clock gating takes effect. The mode is captured at that moment, so later changes to the selector do not alter a sleep already in progress.

An enabled interrupt request ends sleep. The block then turns the oscillator back on and holds the core through the start-up interval, which an external timer marks with a done signal. The core stays held for a fixed number of further cycles (four by default) and is then released with a one-cycle indication that the interrupt handler should run. Execution resumes after the sleep instruction. A core reset request arriving in any non-running phase releases the core at once and gives a separate one-cycle indication that execution restarts from the reset vector. The reset request overrides a simultaneous interrupt.

Top module: `sleep_wake_ctrl`

## Requirements
- R1: While and directly after the block reset (rstN low), every clock enable and the oscillator request are 1, and coreHalt, wakeIrq and wakeRst are 0.
- R2: A sleepInsn pulse while running enters sleep only if sleepEn is 1 on the same cycle. With sleepEn at 0, the outputs stay in the running state.
- R3: Mode code 3'b000 (light) asserts coreHalt and clears only cpuClkEn, from the cycle after the accepted sleepInsn.
- R4: Mode code 3'b001 (quiet) asserts coreHalt and clears cpuClkEn and ioClkEn. auxClkEn and oscEn stay 1.
- R5: Mode code 3'b010 (deep) asserts coreHalt and clears cpuClkEn, ioClkEn, auxClkEn and oscEn.
- R6: Any other mode code (3'b011 to 3'b111) behaves exactly like 3'b000.
- R7: The mode is captured when sleep is entered. Changes on modeSel while sleeping or waking have no effect on the outputs.
- R8: irqReq while sleeping moves to start-up: oscEn goes to 1, coreHalt stays 1 and the domain gating of the mode is kept. startupDone is ignored while sleeping.
- R9: After startupDone is sampled in start-up, coreHalt stays 1 with all clock enables at 1 for exactly HALT_CYC (4) cycles. On the first running cycle after that, wakeIrq is 1 for one cycle.
- R10: coreRst while sleeping, in start-up or in the post-start-up halt returns to running on the next cycle, with wakeRst at 1 for one cycle and no wakeIrq.
- R11: coreRst and irqReq on the same sleeping cycle produce a reset wake (wakeRst), not an interrupt wake.
- R12: coreRst while running gives no wakeRst and blocks a sleepInsn on the same cycle.
- R13: irqReq while running has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low block reset |
| sleepEn | input | 1 | Sleep arm bit |
| modeSel | input | SEL_W (3) | Requested sleep mode code |
| sleepInsn | input | 1 | One-cycle pulse: sleep instruction executed |
| irqReq | input | 1 | Enabled interrupt request |
| coreRst | input | 1 | Core reset request |
| startupDone | input | 1 | Oscillator start-up interval elapsed |
| cpuClkEn | output | 1 | Core clock domain enable |
| ioClkEn | output | 1 | I/O clock domain enable |
| auxClkEn | output | 1 | Remaining clock domain enable |
| oscEn | output | 1 | Oscillator run request |
| coreHalt | output | 1 | Core held |
| wakeIrq | output | 1 | One-cycle pulse: resume via interrupt handler |
| wakeRst | output | 1 | One-cycle pulse: resume from reset vector |

## Verification
The hardest situations to reach are a reset request that lands inside the short post-start-up halt, and a reset request that lands together with an interrupt. Both need exact cycle placement after a full entry, interrupt and start-up sequence. The stimulus steps the design one cycle at a time. Each step carries the expected output vector for the following edge, so a reset can be placed on a chosen halt cycle and the absence of a later interrupt wake can be confirmed. Mode capture is checked by changing the selector during a deep sleep and during start-up.

// File: rtl/swc_pkg.sv
package swc_pkg;

  typedef enum logic [1:0] {
    ST_RUN     = 2'd0,
    ST_SLEEP   = 2'd1,
    ST_STARTUP = 2'd2,
    ST_HALT    = 2'd3
  } state_e;

  typedef enum logic [1:0] {
    M_LIGHT = 2'd0,
    M_QUIET = 2'd1,
    M_DEEP  = 2'd2
  } mode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic loadMode;
    logic clrCnt;
    logic incCnt;
    logic gated;    // sleeping or starting up: apply mode gating
    logic oscWake;  // starting up: oscillator forced on
  } ctrl_t;

endpackage

// File: rtl/swc_dp.sv
module swc_dp
  import swc_pkg::*;
#(
  parameter int HALT_CYC = 4,
  parameter int SEL_W    = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrl_t            ctrl,
  input  logic [SEL_W-1:0] modeSel,
  output logic             cntDone,
  output logic             cpuClkEn,
  output logic             ioClkEn,
  output logic             auxClkEn,
  output logic             oscEn
);

  localparam int CNT_W = (HALT_CYC > 1) ? $clog2(HALT_CYC) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(HALT_CYC - 1);

  mode_e            modeQ;
  mode_e            modeDec;
  logic [CNT_W-1:0] cnt;

  // codes other than quiet and deep fall back to light
  always_comb begin
    if (modeSel == SEL_W'(1))      modeDec = M_QUIET;
    else if (modeSel == SEL_W'(2)) modeDec = M_DEEP;
    else                           modeDec = M_LIGHT;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeQ <= M_LIGHT;
      cnt   <= '0;
    end else begin
      if (ctrl.loadMode) modeQ <= modeDec;
      if (ctrl.clrCnt)      cnt <= '0;
      else if (ctrl.incCnt) cnt <= cnt + 1'b1;
    end
  end

  assign cntDone = (cnt == LAST);

  always_comb begin
    cpuClkEn = 1'b1;
    ioClkEn  = 1'b1;
    auxClkEn = 1'b1;
    oscEn    = 1'b1;
    if (ctrl.gated) begin
      cpuClkEn = 1'b0;
      unique case (modeQ)
        M_QUIET: ioClkEn = 1'b0;
        M_DEEP: begin
          ioClkEn  = 1'b0;
          auxClkEn = 1'b0;
          oscEn    = ctrl.oscWake;
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/swc_ctrl.sv
module swc_ctrl
  import swc_pkg::*;
(
  input  logic  clk,
  input  logic  rstN,
  input  logic  sleepEn,
  input  logic  sleepInsn,
  input  logic  irqReq,
  input  logic  coreRst,
  input  logic  startupDone,
  input  logic  cntDone,
  output ctrl_t ctrl,
  output logic  coreHalt,
  output logic  wakeIrq,
  output logic  wakeRst
);

  state_e state, stateNxt;
  logic   irqWake;

  always_comb begin
    stateNxt = state;
    ctrl     = '0;
    irqWake  = 1'b0;
    unique case (state)
      ST_RUN: begin
        if (!coreRst && sleepInsn && sleepEn) begin
          stateNxt      = ST_SLEEP;
          ctrl.loadMode = 1'b1;
        end
      end
      ST_SLEEP: begin
        ctrl.gated = 1'b1;
        if (coreRst)     stateNxt = ST_RUN;
        else if (irqReq) stateNxt = ST_STARTUP;
      end
      ST_STARTUP: begin
        ctrl.gated   = 1'b1;
        ctrl.oscWake = 1'b1;
        if (coreRst) stateNxt = ST_RUN;
        else if (startupDone) begin
          stateNxt    = ST_HALT;
          ctrl.clrCnt = 1'b1;
        end
      end
      ST_HALT: begin
        if (coreRst) stateNxt = ST_RUN;
        else if (cntDone) begin
          stateNxt = ST_RUN;
          irqWake  = 1'b1;
        end else ctrl.incCnt = 1'b1;
      end
      default: stateNxt = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_RUN;
      wakeIrq <= 1'b0;
      wakeRst <= 1'b0;
    end else begin
      state   <= stateNxt;
      wakeIrq <= irqWake;
      wakeRst <= coreRst && (state != ST_RUN);
    end
  end

  assign coreHalt = (state != ST_RUN);

endmodule

// File: rtl/sleep_wake_ctrl.sv
module sleep_wake_ctrl
  import swc_pkg::*;
#(
  parameter int HALT_CYC = 4,
  parameter int SEL_W    = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sleepEn,
  input  logic [SEL_W-1:0] modeSel,
  input  logic             sleepInsn,
  input  logic             irqReq,
  input  logic             coreRst,
  input  logic             startupDone,
  output logic             cpuClkEn,
  output logic             ioClkEn,
  output logic             auxClkEn,
  output logic             oscEn,
  output logic             coreHalt,
  output logic             wakeIrq,
  output logic             wakeRst
);

  ctrl_t ctrl;
  logic  cntDone;

  swc_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .sleepEn(sleepEn), .sleepInsn(sleepInsn),
    .irqReq(irqReq), .coreRst(coreRst), .startupDone(startupDone),
    .cntDone(cntDone), .ctrl(ctrl), .coreHalt(coreHalt),
    .wakeIrq(wakeIrq), .wakeRst(wakeRst)
  );

  swc_dp #(.HALT_CYC(HALT_CYC), .SEL_W(SEL_W)) u_dp (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .modeSel(modeSel),
    .cntDone(cntDone), .cpuClkEn(cpuClkEn), .ioClkEn(ioClkEn),
    .auxClkEn(auxClkEn), .oscEn(oscEn)
  );

endmodule

// File: rtl/swc_checker.sv
module swc_checker #(
  parameter int HALT_CYC = 4
) (
  input logic clk,
  input logic rstN,
  input logic sleepEn,
  input logic sleepInsn,
  input logic coreRst,
  input logic cpuClkEn,
  input logic ioClkEn,
  input logic auxClkEn,
  input logic oscEn,
  input logic coreHalt,
  input logic wakeIrq,
  input logic wakeRst
);

  localparam int CW = $clog2(HALT_CYC + 2) + 1;
  localparam logic [CW-1:0] SAT = {CW{1'b1}};

  // consecutive cycles held with the core clock running (post start-up halt)
  logic [CW-1:0] holdCnt;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) holdCnt <= '0;
    else if (coreHalt && cpuClkEn) holdCnt <= (holdCnt == SAT) ? SAT : holdCnt + 1'b1;
    else holdCnt <= '0;
  end

  a_r2_needs_enable: assert property (@(posedge clk) disable iff (!rstN)
    (!coreHalt && sleepInsn && !sleepEn) |=> !coreHalt);

  a_r3_entry_halts: assert property (@(posedge clk) disable iff (!rstN)
    (!coreHalt && sleepInsn && sleepEn && !coreRst) |=> (coreHalt && !cpuClkEn));

  a_r5_deep_all_off: assert property (@(posedge clk) disable iff (!rstN)
    (coreHalt && !oscEn) |-> (!cpuClkEn && !ioClkEn && !auxClkEn));

  a_r9_halt_length: assert property (@(posedge clk) disable iff (!rstN)
    wakeIrq |-> (!coreHalt && holdCnt == CW'(HALT_CYC)));

  a_r10_reset_wake: assert property (@(posedge clk) disable iff (!rstN)
    wakeRst |-> (!coreHalt && !wakeIrq && $past(coreRst)));

  a_r12_run_reset: assert property (@(posedge clk) disable iff (!rstN)
    (!coreHalt && coreRst) |=> (!coreHalt && !wakeRst));

endmodule

bind sleep_wake_ctrl swc_checker #(.HALT_CYC(HALT_CYC)) u_swc_checker (
  .clk(clk), .rstN(rstN), .sleepEn(sleepEn), .sleepInsn(sleepInsn),
  .coreRst(coreRst), .cpuClkEn(cpuClkEn), .ioClkEn(ioClkEn),
  .auxClkEn(auxClkEn), .oscEn(oscEn), .coreHalt(coreHalt),
  .wakeIrq(wakeIrq), .wakeRst(wakeRst)
);

// File: tb/sleep_wake_ctrl_bench.sv
module sleep_wake_ctrl_bench;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       sleepEn = 1'b0;
  logic [2:0] modeSel = '0;
  logic       sleepInsn = 1'b0;
  logic       irqReq = 1'b0;
  logic       coreRst = 1'b0;
  logic       startupDone = 1'b0;
  logic cpuClkEn, ioClkEn, auxClkEn, oscEn, coreHalt, wakeIrq, wakeRst;

  sleep_wake_ctrl u_sleep_wake_ctrl (
    .clk(clk), .rstN(rstN), .sleepEn(sleepEn), .modeSel(modeSel),
    .sleepInsn(sleepInsn), .irqReq(irqReq), .coreRst(coreRst),
    .startupDone(startupDone), .cpuClkEn(cpuClkEn), .ioClkEn(ioClkEn),
    .auxClkEn(auxClkEn), .oscEn(oscEn), .coreHalt(coreHalt),
    .wakeIrq(wakeIrq), .wakeRst(wakeRst)
  );

  always #5 clk = ~clk;

  // vector order {cpu, io, aux, osc, halt, wakeIrq, wakeRst}
  localparam logic [6:0] RUN   = 7'b1111000;
  localparam logic [6:0] SL_LT = 7'b0111100;
  localparam logic [6:0] SL_QT = 7'b0011100;
  localparam logic [6:0] SL_DP = 7'b0000100;
  localparam logic [6:0] SU_DP = 7'b0001100;
  localparam logic [6:0] HOLD  = 7'b1111100;
  localparam logic [6:0] W_IRQ = 7'b1111010;
  localparam logic [6:0] W_RST = 7'b1111001;

  typedef struct {
    logic [6:0] v;
    string      tag;
  } item_t;

  item_t expQ[$];
  int    checks = 0;
  int    errors = 0;

  // driver: apply inputs before an edge, queue what the edge should give
  task automatic step(input logic en, input logic [2:0] m, input logic insn,
                      input logic irq, input logic rst, input logic sud,
                      input logic [6:0] exp, input string tag);
    item_t it;
    sleepEn = en; modeSel = m; sleepInsn = insn;
    irqReq = irq; coreRst = rst; startupDone = sud;
    it.v = exp; it.tag = tag;
    expQ.push_back(it);
    @(negedge clk);
  endtask

  task automatic idle(input logic [2:0] m, input logic [6:0] exp, input string tag);
    step(1'b0, m, 1'b0, 1'b0, 1'b0, 1'b0, exp, tag);
  endtask

  task automatic holdPhase(input string tag);
    for (int i = 0; i < 3; i++) idle(3'd0, HOLD, tag);
  endtask

  // monitor: compare after each edge
  always @(posedge clk) begin
    item_t it;
    logic [6:0] act;
    #2;
    if (expQ.size() > 0) begin
      it  = expQ.pop_front();
      act = {cpuClkEn, ioClkEn, auxClkEn, oscEn, coreHalt, wakeIrq, wakeRst};
      checks++;
      if (act !== it.v) begin
        errors++;
        $display("FAIL %s actual=%b expected=%b", it.tag, act, it.v);
      end
    end
  end

  initial begin
    #1_000_000;
    errors++; checks++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    @(negedge clk);
    idle(3'd0, RUN, "R1 in reset");
    idle(3'd0, RUN, "R1 in reset");
    rstN = 1'b1;
    idle(3'd0, RUN, "R1 after reset");

    // R13 interrupt while running
    step(0, 3'd0, 0, 1, 0, 0, RUN, "R13 irq running");
    idle(3'd0, RUN, "R13 after");

    // R2 no entry without enable
    step(0, 3'd0, 1, 0, 0, 0, RUN, "R2 disabled insn");
    idle(3'd0, RUN, "R2 after");

    // R3 light mode, full interrupt wake
    step(1, 3'd0, 1, 0, 0, 0, SL_LT, "R3 light entry");
    idle(3'd0, SL_LT, "R3 light hold");
    step(0, 3'd0, 0, 0, 0, 1, SL_LT, "R8 done ignored asleep");
    step(0, 3'd0, 0, 1, 0, 0, SL_LT, "R8 light startup");
    idle(3'd0, SL_LT, "R8 light startup wait");
    step(0, 3'd0, 0, 0, 0, 1, HOLD, "R9 hold 1");
    holdPhase("R9 hold");
    idle(3'd0, W_IRQ, "R9 irq wake");
    idle(3'd0, RUN, "R9 pulse ends");

    // R4 quiet mode
    step(1, 3'd1, 1, 0, 0, 0, SL_QT, "R4 quiet entry");
    step(0, 3'd1, 0, 1, 0, 0, SL_QT, "R8 quiet startup");
    step(0, 3'd1, 0, 0, 0, 1, HOLD, "R9 quiet hold 1");
    holdPhase("R9 quiet hold");
    idle(3'd1, W_IRQ, "R9 quiet wake");
    idle(3'd1, RUN, "R4 back to run");

    // R5 deep mode
    step(1, 3'd2, 1, 0, 0, 0, SL_DP, "R5 deep entry");
    idle(3'd2, SL_DP, "R5 deep hold");
    step(0, 3'd2, 0, 1, 0, 0, SU_DP, "R8 deep startup osc on");
    step(0, 3'd2, 0, 0, 0, 1, HOLD, "R9 deep hold 1");
    holdPhase("R9 deep hold");
    idle(3'd2, W_IRQ, "R9 deep wake");
    idle(3'd2, RUN, "R5 back to run");

    // R6 reserved code 5, then reset wake from sleep
    step(1, 3'd5, 1, 0, 0, 0, SL_LT, "R6 code 5 as light");
    step(0, 3'd5, 0, 0, 1, 0, W_RST, "R10 reset from sleep");
    idle(3'd5, RUN, "R10 pulse ends");

    // R7 mode captured; reset wake from start-up
    step(1, 3'd2, 1, 0, 0, 0, SL_DP, "R7 deep entry");
    idle(3'd1, SL_DP, "R7 select to quiet ignored");
    idle(3'd0, SL_DP, "R7 select to light ignored");
    step(0, 3'd0, 0, 1, 0, 0, SU_DP, "R7 startup keeps deep");
    step(0, 3'd0, 0, 0, 1, 0, W_RST, "R10 reset from startup");
    idle(3'd0, RUN, "R10 pulse ends");

    // R6 code 3; reset inside the post start-up hold
    step(1, 3'd3, 1, 0, 0, 0, SL_LT, "R6 code 3 as light");
    step(0, 3'd3, 0, 1, 0, 0, SL_LT, "R8 startup code 3");
    step(0, 3'd3, 0, 0, 0, 1, HOLD, "R9 hold before reset");
    step(0, 3'd3, 0, 0, 1, 0, W_RST, "R10 reset from hold");
    idle(3'd3, RUN, "R10 no irq wake 1");
    idle(3'd3, RUN, "R10 no irq wake 2");
    idle(3'd3, RUN, "R10 no irq wake 3");
    idle(3'd3, RUN, "R10 no irq wake 4");

    // R11 reset and interrupt together
    step(1, 3'd1, 1, 0, 0, 0, SL_QT, "R11 quiet entry");
    step(0, 3'd1, 0, 1, 1, 0, W_RST, "R11 reset beats irq");
    idle(3'd1, RUN, "R11 after");

    // R12 reset while running blocks entry
    step(1, 3'd0, 1, 0, 1, 0, RUN, "R12 reset with insn");
    idle(3'd0, RUN, "R12 after");

    @(negedge clk);
    @(negedge clk);
    if (expQ.size() != 0) begin
      errors++; checks++;
      $display("FAIL queue actual=%0d expected=0", expQ.size());
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule